// File: doc/BRIEF.md
# Task-Switched Page Translation Unit

This unit sits between an 8-bit processor's 16-bit address bus and the memory arrays of a small system. The logical space is cut into sixteen 4 KB windows. Each window is redirected to one of sixteen 4 KB physical pages through a lookup table, and sixteen such tables are held side by side, one for each task. A single task register picks the table in force. Switching tasks therefore remaps the whole address space with one store.

The same task register carries an overlay bit that reshuffles which 2 KB ROM images show up in the upper physical region. The page table entries are write-only and are reached through the last sixteen bytes of the address space. Every read from the top 256 bytes of logical space returns a fixed ROM page. The unit produces the translated physical address, a RAM select, a ROM select with an image number and an offset into that image, and an echo of each table store. The RAM and ROM arrays are outside this block.

Top module: `dmt_unit`

## Requirements
- R1: For a logical address below 0xFF00, `phys_addr` equals the 4-bit page number in bits 15..12, followed by the untouched low 12 bits of the logical address.
- R2: The page number used is the entry of the active task's table indexed by logical address bits 15..12.
- R3: A write to 0xFF7F loads the task number from data bits 3..0 and the overlay bit from data bit 5. Both appear on `active_task` and `overlay_on` from the cycle after the write.
- R4: After a task switch, every window translates through the new task's table from the next cycle on.
- R5: A write to 0xFFF0+n stores data bits 3..0 in entry n of the active task's table, with effect from the next cycle. The tables of other tasks are left untouched.
- R6: A read of 0xFF00–0xFFFF asserts `rom_sel` and not `ram_sel`. The image is 0 with the overlay bit clear and 2 with it set, and `rom_offset` is 0x700 plus logical address bits 7..0.
- R7: A read whose physical address lies at 0xE800 or above, from a logical address below 0xFF00, asserts `rom_sel` with `rom_offset` equal to physical bits 10..0. The image depends on the 2 KB region: for 0xE800, 0xF000 and 0xF800 it is 2, 1 and 0 with the overlay bit clear, and 1, 3 and 2 with it set.
- R8: `ram_sel` is high exactly for a read or write from a logical address below 0xFF00 that maps below physical 0xE800. A write that lands in a physical ROM region or in the top logical page asserts neither select, and an idle cycle asserts neither.
- R9: During a write to 0xFFF0–0xFFFF, `map_we` is high in the same cycle, with `map_task` equal to the active task, `map_slot` equal to address bits 3..0 and `map_page` equal to data bits 3..0. `map_we` is low in every other cycle.
- R10: Reset sets the active task to 0 and clears the overlay bit. Table contents are not defined by reset.
- R11: Writes to other addresses in 0xFF00–0xFFEF change neither the task, the overlay bit nor any table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Logical address |
| cpu_rd | input | 1 | Read cycle |
| cpu_wr | input | 1 | Write cycle |
| cpu_wdata | input | 8 | Write data |
| phys_addr | output | 16 | Translated physical address |
| ram_sel | output | 1 | Access goes to RAM |
| rom_sel | output | 1 | Read served from ROM |
| rom_image | output | 2 | ROM image number when `rom_sel` is high |
| rom_offset | output | 11 | Byte offset inside the 2 KB image |
| active_task | output | 4 | Task in force |
| overlay_on | output | 1 | ROM overlay bit |
| map_we | output | 1 | A table entry is being written |
| map_task | output | 4 | Task whose table is written |
| map_slot | output | 4 | Entry index written |
| map_page | output | 4 | Page number written |

## Verification
Translation, the selects, the ROM image and offset, and the table-write echo are combinational. They are due in the same cycle as the address that causes them. A store to the task register or to a table entry shows up only from the cycle after its clock edge. The bench drives each access just after a falling edge and compares every output 1 ns later against a behavioural model. The model applies stores only at rising edges, so same-cycle and next-cycle effects are checked in the cycles where each one is due.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int PAGE_W    = 4;
    localparam int NUM_WIN   = 16;
    localparam int NUM_TASK  = 16;
    localparam int WIN_W     = $clog2(NUM_WIN);
    localparam int TASK_W    = $clog2(NUM_TASK);
    localparam int OFF_W     = ADDR_W - WIN_W;
    localparam int ROM_OFF_W = 11;
    localparam int ROM_IMG_W = 2;
    localparam int OVL_BIT   = 5;

    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [TASK_W-1:0]    task_id_t;
    typedef logic [PAGE_W-1:0]    page_t;
    typedef logic [WIN_W-1:0]     win_t;
    typedef logic [ROM_IMG_W-1:0] img_t;
    typedef page_t [NUM_WIN-1:0]  page_row_t;

    typedef struct packed {
        task_id_t id;
        logic     overlay;
    } task_state_t;

    typedef enum logic [1:0] {
        RW_LOW   = 2'd0,
        RW_MID   = 2'd1,
        RW_HIGH  = 2'd2,
        RW_FIXED = 2'd3
    } rom_win_e;

    function automatic img_t rom_image_of(rom_win_e w, logic ovl);
        img_t r;
        case (w)
            RW_LOW:  r = ovl ? img_t'(1) : img_t'(2);
            RW_MID:  r = ovl ? img_t'(3) : img_t'(1);
            RW_HIGH: r = ovl ? img_t'(2) : img_t'(0);
            default: r = ovl ? img_t'(2) : img_t'(0);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/dmt_task_reg.sv
module dmt_task_reg
    import dmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [DATA_W-1:0]   din,
    output task_state_t         st
);
    task_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.id      = din[TASK_W-1:0];
            st_d.overlay = din[OVL_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    assert_task_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st.id == $past(din[TASK_W-1:0]) && st.overlay == $past(din[OVL_BIT])));

    assert_task_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st));
endmodule

// File: rtl/dmt_map_file.sv
module dmt_map_file
    import dmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  task_id_t  wr_task,
    input  win_t      wr_slot,
    input  page_t     wr_page,
    input  task_id_t  rd_task,
    output page_row_t rd_row
);
    page_row_t rows [NUM_TASK];

    for (genvar t = 0; t < NUM_TASK; t++) begin : g_task
        page_row_t row_d, row_q;

        always_comb begin
            row_d = row_q;
            if (we && wr_task == task_id_t'(t))
                row_d[wr_slot] = wr_page;
        end

        always_ff @(posedge clk) row_q <= row_d;

        assign rows[t] = row_q;
    end

    assign rd_row = rows[rd_task];

    assert_entry_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_task == rd_task) |=>
            ($stable(rd_task) -> rd_row[$past(wr_slot)] == $past(wr_page)));
endmodule

// File: rtl/dmt_translate.sv
module dmt_translate
    import dmt_pkg::*;
#(
    parameter addr_t TOP_BASE = 16'hFF00,
    parameter addr_t ROM_BASE = 16'hE800,
    parameter logic [ROM_OFF_W-1:0] FIXED_OFF = 11'h700
) (
    input  addr_t                 addr,
    input  logic                  rd,
    input  logic                  wr,
    input  logic                  overlay,
    input  page_row_t             row,
    output addr_t                 phys,
    output logic                  ram_sel,
    output logic                  rom_sel,
    output img_t                  image,
    output logic [ROM_OFF_W-1:0]  offset
);
    localparam int FIX_LOW_W = 8;

    win_t     win;
    page_t    page;
    logic     in_top;
    logic     in_rom;
    addr_t    rom_rel;
    rom_win_e which;

    always_comb begin
        win     = addr[ADDR_W-1 -: WIN_W];
        page    = row[win];
        phys    = {page, addr[OFF_W-1:0]};
        in_top  = addr >= TOP_BASE;
        in_rom  = phys >= ROM_BASE;
        rom_rel = phys - ROM_BASE;
        which   = in_top ? RW_FIXED : rom_win_e'(rom_rel[ROM_OFF_W +: 2]);

        ram_sel = (rd || wr) && !in_top && !in_rom;
        rom_sel = rd && (in_top || in_rom);
        image   = rom_image_of(which, overlay);
        if (in_top)
            offset = FIXED_OFF + {{(ROM_OFF_W-FIX_LOW_W){1'b0}}, addr[FIX_LOW_W-1:0]};
        else
            offset = phys[ROM_OFF_W-1:0];
    end
endmodule

// File: rtl/dmt_unit.sv
module dmt_unit
    import dmt_pkg::*;
#(
    parameter logic [15:0] TASK_ADDR = 16'hFF7F,
    parameter logic [15:0] MAP_BASE  = 16'hFFF0,
    parameter logic [15:0] TOP_BASE  = 16'hFF00,
    parameter logic [15:0] ROM_BASE  = 16'hE800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic [7:0]  cpu_wdata,
    output logic [15:0] phys_addr,
    output logic        ram_sel,
    output logic        rom_sel,
    output logic [1:0]  rom_image,
    output logic [10:0] rom_offset,
    output logic [3:0]  active_task,
    output logic        overlay_on,
    output logic        map_we,
    output logic [3:0]  map_task,
    output logic [3:0]  map_slot,
    output logic [3:0]  map_page
);
    task_state_t ts;
    page_row_t   row;
    logic        task_load;

    assign task_load = cpu_wr && (cpu_addr == TASK_ADDR);
    assign map_we    = cpu_wr && (cpu_addr >= MAP_BASE);
    assign map_task  = ts.id;
    assign map_slot  = cpu_addr[WIN_W-1:0];
    assign map_page  = cpu_wdata[PAGE_W-1:0];

    dmt_task_reg u_task (
        .clk  (clk),
        .rst_n(rst_n),
        .load (task_load),
        .din  (cpu_wdata),
        .st   (ts)
    );

    dmt_map_file u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (map_we),
        .wr_task(ts.id),
        .wr_slot(map_slot),
        .wr_page(map_page),
        .rd_task(ts.id),
        .rd_row (row)
    );

    dmt_translate #(
        .TOP_BASE(TOP_BASE),
        .ROM_BASE(ROM_BASE)
    ) u_xlat (
        .addr   (cpu_addr),
        .rd     (cpu_rd),
        .wr     (cpu_wr),
        .overlay(ts.overlay),
        .row    (row),
        .phys   (phys_addr),
        .ram_sel(ram_sel),
        .rom_sel(rom_sel),
        .image  (rom_image),
        .offset (rom_offset)
    );

    assign active_task = ts.id;
    assign overlay_on  = ts.overlay;

    assert_top_read_rom_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr >= MAP_BASE) |-> (rom_sel && !ram_sel));

    assert_sel_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_sel && rom_sel));

    assert_no_table_on_task_R9: assert property (@(posedge clk) disable iff (!rst_n)
        task_load |-> !map_we);
endmodule

// File: tb/dmt_unit_bench.sv
module dmt_unit_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [15:0] phys_addr;
    logic        ram_sel, rom_sel, overlay_on, map_we;
    logic [1:0]  rom_image;
    logic [10:0] rom_offset;
    logic [3:0]  active_task, map_task, map_slot, map_page;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit tables_known = 0;

    int mt [16][16];
    int mtask = 0;
    bit movl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmt_unit u_dmt_unit (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .phys_addr(phys_addr),
        .ram_sel(ram_sel), .rom_sel(rom_sel), .rom_image(rom_image),
        .rom_offset(rom_offset), .active_task(active_task), .overlay_on(overlay_on),
        .map_we(map_we), .map_task(map_task), .map_slot(map_slot), .map_page(map_page)
    );

    // behavioural reference: stores take effect at the rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mtask <= 0;
            movl  <= 0;
        end else if (cpu_wr) begin
            if (cpu_addr == 16'hFF7F) begin
                mtask <= int'(cpu_wdata) % 16;
                movl  <= cpu_wdata[5];
            end
            if (int'(cpu_addr) >= 'hFFF0)
                mt[mtask][int'(cpu_addr) % 16] = int'(cpu_wdata) % 16;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int a, page, phys, eimg, eoff;
        bit top, inrom, erom, eram, emwe;
        a     = int'(cpu_addr);
        top   = a >= 'hFF00;
        page  = mt[mtask][a / 4096];
        phys  = page * 4096 + a % 4096;
        inrom = phys >= 'hE800;
        chk(active_task == 4'(mtask), "R3 R4 R10", "active_task", active_task, mtask);
        chk(overlay_on == movl, "R3 R10", "overlay_on", overlay_on, movl);
        emwe = cpu_wr && a >= 'hFFF0;
        chk(map_we == emwe, "R9", "map_we", map_we, emwe);
        if (emwe) begin
            chk(map_task == 4'(mtask), "R9", "map_task", map_task, mtask);
            chk(map_slot == 4'(a % 16), "R9", "map_slot", map_slot, a % 16);
            chk(map_page == cpu_wdata[3:0], "R9", "map_page", map_page, cpu_wdata[3:0]);
        end
        if (!tables_known && !top) return;
        if (top) begin
            erom = cpu_rd;
            eram = 0;
        end else begin
            chk(phys_addr == 16'(phys), "R1 R2 R4 R5", "phys_addr", phys_addr, phys);
            erom = cpu_rd && inrom;
            eram = (cpu_rd || cpu_wr) && !inrom;
        end
        chk(ram_sel == eram, "R8", "ram_sel", ram_sel, eram);
        chk(rom_sel == erom, top ? "R6" : "R7", "rom_sel", rom_sel, erom);
        if (erom) begin
            if (top) begin
                eimg = movl ? 2 : 0;
                eoff = 'h700 + a % 256;
                chk(rom_image == 2'(eimg), "R6", "fixed image", rom_image, eimg);
                chk(rom_offset == 11'(eoff), "R6", "fixed offset", rom_offset, eoff);
            end else begin
                case ((phys - 'hE800) / 2048)
                    0: eimg = movl ? 1 : 2;
                    1: eimg = movl ? 3 : 1;
                    default: eimg = movl ? 2 : 0;
                endcase
                eoff = phys % 2048;
                chk(rom_image == 2'(eimg), "R7", "window image", rom_image, eimg);
                chk(rom_offset == 11'(eoff), "R7", "window offset", rom_offset, eoff);
            end
        end
    endtask

    task automatic acc(input int a, input bit w, input bit r, input int d);
        @(negedge clk);
        cpu_addr  = 16'(a);
        cpu_wr    = w;
        cpu_rd    = r;
        cpu_wdata = 8'(d);
        #1 compare();
    endtask

    task automatic sweep(input int salt);
        for (int w = 0; w < 15; w++) acc(w * 4096 + salt + w * 17, 0, 1, 0);
        for (int w = 0; w < 15; w++) acc(w * 4096 + 'hFFF - salt, 1, 0, 'h55);
    endtask

    initial begin
        while (cycles < WATCHDOG) @(posedge clk) cycles++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", cycles, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state seen through the task outputs and the fixed page
        acc('hFF00, 0, 1, 0);
        acc('hFF42, 0, 0, 0);
        // R3 R5 R9: load every task's table
        for (int t = 0; t < 16; t++) begin
            acc('hFF7F, 1, 0, t);
            for (int s = 0; s < 16; s++) acc('hFFF0 + s, 1, 0, 'hA0 | ((t * 7 + s * 3 + 1) % 16));
        end
        tables_known = 1;
        // R1 R2 R4: sweep under several tasks
        acc('hFF7F, 1, 0, 0);
        sweep('h123);
        acc('hFF7F, 1, 0, 5);
        sweep('h040);
        acc('hFF7F, 1, 0, 15);
        sweep('h7FE);
        // R7 R8: force ROM pages into windows 2..4 of task 3, overlay set
        acc('hFF7F, 1, 0, 'h23);
        acc('hFFF2, 1, 0, 14);
        acc('hFFF3, 1, 0, 15);
        acc('hFFF4, 1, 0, 13);
        for (int k = 0; k < 2; k++) begin
            acc('h2000, 0, 1, 0);
            acc('h27FF, 0, 1, 0);
            acc('h2800, 0, 1, 0);
            acc('h2FFF, 0, 1, 0);
            acc('h3000, 0, 1, 0);
            acc('h37FF, 0, 1, 0);
            acc('h3800, 0, 1, 0);
            acc('h3FFF, 0, 1, 0);
            acc('h4ABC, 0, 1, 0);
            acc('h2900, 1, 0, 'h11);
            acc('h3C00, 1, 0, 'h22);
            acc('h3C00, 0, 0, 0);
            // R6: the whole top page, including the table addresses
            for (int b = 'hFF00; b <= 'hFFFF; b += 'h11) acc(b, 0, 1, 0);
            for (int s = 0; s < 16; s++) acc('hFFF0 + s, 0, 1, 0);
            acc('hFF7F, 1, 0, 3);
        end
        // R11: stray stores to the top page
        acc('hFF00, 1, 0, 'h2F);
        acc('hFF7E, 1, 0, 'h2A);
        acc('hFF80, 1, 0, 'hFF);
        acc('hFFEF, 1, 0, 'h29);
        sweep('h333);
        // R5: other tasks untouched by task 3 edits
        acc('hFF7F, 1, 0, 4);
        sweep('h010);
        acc('hFF7F, 1, 0, 2);
        sweep('h020);
        acc('h0000, 0, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule